// File: doc/BRIEF.md
# Direct-Mapped Cache Hit/Miss Profiler

This block models the tag side of a direct-mapped data cache so that the hit and miss behaviour of an address stream can be measured in hardware. Each access is a whole-word read or write at a 32-bit byte address that is a multiple of four. The block looks up the set picked by the address, decides hit or miss, installs the tag on a miss, and keeps saturating counters of accesses and of hits and misses for reads and for writes. It stores no data and models no memory traffic.

Capacity in bytes and words per block are parameters. The set index and tag positions follow from them: the byte offset takes log2(bytes per word) bits, the block offset log2(words per block) bits, the set index log2(sets) bits, and the tag takes the rest. At 4 KB with 4-byte words the tag is always bits 31:12. Accesses are offered with a valid/ready handshake at one per cycle. The hit/miss result and a one-cycle result strobe come out on the cycle after acceptance. A synchronous clear empties the cache and zeroes the counters.

Top module: `cache_profiler`

## Requirements
- R1: Set index and tag come from the geometry parameters. At 4 KB capacity: with 1-word blocks the set is bits 11:2; with 4-word blocks the block offset is bits 3:2 and the set is bits 11:4; with 16-word blocks the block offset is bits 5:2 and the set is bits 11:6. In every case the tag is bits 31:12. Words in one block share one entry.
- R2: An access hits only when the indexed set is valid and its stored tag equals the address tag. Otherwise it misses.
- R3: A miss makes the indexed set valid and replaces its tag with the address tag. A later access to a different tag in the same set evicts the earlier block. An access that directly follows another access in the next cycle sees that access's update.
- R4: A write miss installs the tag exactly as a read miss does. A write hit leaves the cache state unchanged.
- R5: After reset or clear every set is invalid, so the first access to any set misses.
- R6: While clear_i is high, req_ready_o is low and no access is accepted. One cycle after clear_i is sampled high, all five counters read 0 and res_valid_o is 0.
- R7: req_ready_o is 1 whenever clear_i is low. res_valid_o is 1 for exactly the cycle after an accepted access and 0 in every other cycle. res_hit_o holds that access's result.
- R8: Counters for total accesses, read hits, read misses, write hits and write misses each step by one for a matching accepted access. The new values are visible in the same cycle as res_valid_o. With no accepted access they hold.
- R9: Each counter is CNT_W bits wide (default 32) and stays at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of valid bits and counters |
| req_valid_i | input | 1 | Access offered |
| req_ready_o | output | 1 | Access can be accepted |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 32 | Byte address, word aligned |
| res_valid_o | output | 1 | Result strobe, one cycle after acceptance |
| res_hit_o | output | 1 | 1 hit, 0 miss |
| acc_cnt_o | output | CNT_W | Accepted accesses |
| rd_hit_cnt_o | output | CNT_W | Read hits |
| rd_miss_cnt_o | output | CNT_W | Read misses |
| wr_hit_cnt_o | output | CNT_W | Write hits |
| wr_miss_cnt_o | output | CNT_W | Write misses |

## Verification
A wrong valid bit or stored tag shows up on the next access that maps to that set. The bench reruns a word sweep over the same blocks, so the fault appears as a flipped res_hit_o within a few accesses and as a counter split that differs from the model in that same cycle. A wrong set split separates the three geometries run side by side: the same stream must give one miss per block in each. A counter that wraps or misses a clear differs from the model on the first cycle after the event.

// File: rtl/cp_pkg.sv
package cp_pkg;
  typedef enum int unsigned {
    CNT_ACC     = 0,
    CNT_RD_HIT  = 1,
    CNT_RD_MISS = 2,
    CNT_WR_HIT  = 3,
    CNT_WR_MISS = 4
  } cnt_idx_e;

  localparam int unsigned NUM_CNT = 5;

  function automatic int unsigned safe_log2(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/cp_addr_split.sv
module cp_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LOW_W  = 2,
  parameter int unsigned SET_W  = 10,
  parameter int unsigned TAG_W  = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SET_W-1:0]  set_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_low;

  assign set_o      = addr_i[LOW_W +: SET_W];
  assign tag_o      = addr_i[ADDR_W-1 -: TAG_W];
  assign unused_low = ^addr_i[LOW_W-1:0];
endmodule

// File: rtl/cp_tag_store.sv
module cp_tag_store #(
  parameter int unsigned SETS  = 1024,
  parameter int unsigned SET_W = 10,
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             install_i,
  output logic             hit_o
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign hit_o = valid_q[set_i] && (tag_q[set_i] == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (install_i) begin
      valid_q[set_i] <= 1'b1;
    end
  end

  // tags need no reset: gated by valid
  always_ff @(posedge clk_i) begin
    if (install_i && !clear_i) tag_q[set_i] <= tag_i;
  end
endmodule

// File: rtl/cp_sat_counter.sv
module cp_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (inc_i && !(&cnt_q))    cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cache_profiler.sv
module cache_profiler
  import cp_pkg::*;
#(
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned CAPACITY_BYTES  = 4096,
  parameter int unsigned WORDS_PER_BLOCK = 1,
  parameter int unsigned BYTES_PER_WORD  = 4,
  parameter int unsigned CNT_W           = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [31:0]       req_addr_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [CNT_W-1:0]  acc_cnt_o,
  output logic [CNT_W-1:0]  rd_hit_cnt_o,
  output logic [CNT_W-1:0]  rd_miss_cnt_o,
  output logic [CNT_W-1:0]  wr_hit_cnt_o,
  output logic [CNT_W-1:0]  wr_miss_cnt_o
);
  localparam int unsigned BYTE_OFF_W = $clog2(BYTES_PER_WORD);
  localparam int unsigned BLK_OFF_W  = $clog2(WORDS_PER_BLOCK);
  localparam int unsigned LOW_W      = BYTE_OFF_W + BLK_OFF_W;
  localparam int unsigned SETS       = CAPACITY_BYTES / (WORDS_PER_BLOCK * BYTES_PER_WORD);
  localparam int unsigned SET_W      = safe_log2(SETS);
  localparam int unsigned TAG_W      = ADDR_W - SET_W - LOW_W;

  logic             accept;
  logic             hit;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             res_valid_q, res_hit_q;
  logic [NUM_CNT-1:0]  inc;
  logic [CNT_W-1:0]    cnt [NUM_CNT];

  assign req_ready_o = !clear_i;
  assign accept      = req_valid_i && !clear_i;

  cp_addr_split #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_split (
    .addr_i(req_addr_i[ADDR_W-1:0]),
    .set_o (set_idx),
    .tag_o (tag)
  );

  cp_tag_store #(
    .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .set_i    (set_idx),
    .tag_i    (tag),
    .install_i(accept && !hit),
    .hit_o    (hit)
  );

  always_comb begin
    inc              = '0;
    inc[CNT_ACC]     = accept;
    inc[CNT_RD_HIT]  = accept && !req_write_i &&  hit;
    inc[CNT_RD_MISS] = accept && !req_write_i && !hit;
    inc[CNT_WR_HIT]  = accept &&  req_write_i &&  hit;
    inc[CNT_WR_MISS] = accept &&  req_write_i && !hit;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    cp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .inc_i  (inc[i]),
      .count_o(cnt[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
    end else if (clear_i) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
    end else begin
      res_valid_q <= accept;
      if (accept) res_hit_q <= hit;
    end
  end

  assign res_valid_o   = res_valid_q;
  assign res_hit_o     = res_hit_q;
  assign acc_cnt_o     = cnt[CNT_ACC];
  assign rd_hit_cnt_o  = cnt[CNT_RD_HIT];
  assign rd_miss_cnt_o = cnt[CNT_RD_MISS];
  assign wr_hit_cnt_o  = cnt[CNT_WR_HIT];
  assign wr_miss_cnt_o = cnt[CNT_WR_MISS];
endmodule

// File: rtl/cp_checker.sv
module cp_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [31:0]      req_addr_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [CNT_W-1:0] acc_cnt_o,
  input logic [CNT_W-1:0] rd_hit_cnt_o,
  input logic [CNT_W-1:0] rd_miss_cnt_o,
  input logic [CNT_W-1:0] wr_hit_cnt_o,
  input logic [CNT_W-1:0] wr_miss_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r7_result_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> res_valid_o);

  a_r7_no_result_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !res_valid_o);

  a_r6_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_cnt_o == '0 && rd_hit_cnt_o == '0 && rd_miss_cnt_o == '0 &&
                 wr_hit_cnt_o == '0 && wr_miss_cnt_o == '0));

  a_r8_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !clear_i && acc_cnt_o != CMAX)
      |=> acc_cnt_o == $past(acc_cnt_o) + 1'b1);

  a_r8_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(req_valid_i && req_ready_o)) |=> $stable(acc_cnt_o));

  a_r9_acc_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && acc_cnt_o == CMAX) |=> acc_cnt_o == CMAX);

  // R3: repeat of the just-accepted address must hit
  a_r3_repeat_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && res_valid_o && req_addr_i == $past(req_addr_i))
      |=> res_hit_o);
endmodule

bind cache_profiler cp_checker #(.CNT_W(CNT_W)) u_cp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .acc_cnt_o    (acc_cnt_o),
  .rd_hit_cnt_o (rd_hit_cnt_o),
  .rd_miss_cnt_o(rd_miss_cnt_o),
  .wr_hit_cnt_o (wr_hit_cnt_o),
  .wr_miss_cnt_o(wr_miss_cnt_o)
);

// File: tb/tb_cache_profiler.sv
module tb_cache_profiler;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;

  logic        rdy [NG];
  logic        rv  [NG];
  logic        rh  [NG];
  logic [31:0] c0  [5];
  logic [2:0]  c1n [5];
  logic [31:0] c2  [5];

  int errors = 0;
  int checks = 0;

  // model state
  int     wpb_lg [NG] = '{0, 2, 4};
  longint cmax   [NG] = '{64'hFFFF_FFFF, 7, 64'hFFFF_FFFF};
  bit     mv  [NG][1024];
  int     mt  [NG][1024];
  longint ec  [NG][5];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_profiler dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
    .req_ready_o(rdy[0]), .req_write_i(req_write), .req_addr_i(req_addr),
    .res_valid_o(rv[0]), .res_hit_o(rh[0]),
    .acc_cnt_o(c0[0]), .rd_hit_cnt_o(c0[1]), .rd_miss_cnt_o(c0[2]),
    .wr_hit_cnt_o(c0[3]), .wr_miss_cnt_o(c0[4]));

  cache_profiler #(.WORDS_PER_BLOCK(4), .CNT_W(3)) dut_w4 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
    .req_ready_o(rdy[1]), .req_write_i(req_write), .req_addr_i(req_addr),
    .res_valid_o(rv[1]), .res_hit_o(rh[1]),
    .acc_cnt_o(c1n[0]), .rd_hit_cnt_o(c1n[1]), .rd_miss_cnt_o(c1n[2]),
    .wr_hit_cnt_o(c1n[3]), .wr_miss_cnt_o(c1n[4]));

  cache_profiler #(.WORDS_PER_BLOCK(16)) dut_w16 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
    .req_ready_o(rdy[2]), .req_write_i(req_write), .req_addr_i(req_addr),
    .res_valid_o(rv[2]), .res_hit_o(rh[2]),
    .acc_cnt_o(c2[0]), .rd_hit_cnt_o(c2[1]), .rd_miss_cnt_o(c2[2]),
    .wr_hit_cnt_o(c2[3]), .wr_miss_cnt_o(c2[4]));

  function automatic longint cnt_of(int g, int k);
    if (g == 0) return c0[k];
    if (g == 1) return {61'b0, c1n[k]};
    return c2[k];
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < 1024; s++) mv[g][s] = 1'b0;
      for (int k = 0; k < 5; k++) ec[g][k] = 0;
    end
  endtask

  task automatic bump(int g, int k);
    if (ec[g][k] < cmax[g]) ec[g][k]++;
  endtask

  task automatic check_counters(string rq);
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < 5; k++)
        chk(cnt_of(g, k) == ec[g][k], rq, $sformatf("inst%0d counter%0d", g, k),
            cnt_of(g, k), ec[g][k]);
  endtask

  // one accepted access, back-to-back with the previous call
  task automatic do_access(bit w, logic [31:0] a, string rq);
    bit hit_e [NG];
    req_valid = 1'b1; req_write = w; req_addr = a;
    for (int g = 0; g < NG; g++) begin
      int sets = 1024 >> wpb_lg[g];
      int s = int'((a >> (2 + wpb_lg[g])) % sets);
      int t = int'(a >> 12);
      hit_e[g] = mv[g][s] && (mt[g][s] == t);
      if (!hit_e[g]) begin mv[g][s] = 1'b1; mt[g][s] = t; end
      bump(g, 0);
      bump(g, (w ? 3 : 1) + (hit_e[g] ? 0 : 1));
    end
    @(posedge clk); @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      chk(rv[g] === 1'b1, rq, $sformatf("inst%0d res_valid @%h", g, a), rv[g], 1);
      chk(rh[g] === hit_e[g], rq, $sformatf("inst%0d hit @%h", g, a), rh[g], hit_e[g]);
    end
    check_counters(rq);
  endtask

  task automatic go_idle(string rq);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    for (int g = 0; g < NG; g++)
      chk(rv[g] === 1'b0, rq, $sformatf("inst%0d res_valid idle", g), rv[g], 0);
    check_counters(rq);
  endtask

  task automatic t_reset();
    for (int g = 0; g < NG; g++) begin
      chk(rdy[g] === 1'b1, "R7", "ready after reset", rdy[g], 1);
      chk(rv[g] === 1'b0, "R5", "res_valid after reset", rv[g], 0);
    end
    check_counters("R8");
  endtask

  // R1 R2 R3 R5: cold sweep of 32 words, then warm rerun
  task automatic t_sweep();
    for (int i = 0; i < 32; i++) do_access(1'b0, 32'h1000_1000 + 32'(i*4), "R5");
    for (int i = 0; i < 32; i++) do_access(1'b0, 32'h1000_1000 + 32'(i*4), "R1");
    go_idle("R7");
  endtask

  // R3: same set, different tag evicts
  task automatic t_conflict();
    do_access(1'b0, 32'h1000_2000, "R3");
    do_access(1'b0, 32'h1000_1000, "R3");
    do_access(1'b0, 32'h1000_1000, "R2");
    do_access(1'b0, 32'h2000_1004, "R3");
    do_access(1'b0, 32'h1000_1004, "R3");
    go_idle("R8");
  endtask

  // R4: write allocate, write hit keeps state
  task automatic t_write();
    do_access(1'b1, 32'h3000_0400, "R4");
    do_access(1'b0, 32'h3000_0400, "R4");
    do_access(1'b1, 32'h3000_0400, "R4");
    do_access(1'b0, 32'h3000_0400, "R4");
    do_access(1'b1, 32'h3000_0000, "R4");
    go_idle("R8");
  endtask

  // R6 R5: clear with a request pending
  task automatic t_clear();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h1000_1000;
    clear = 1'b1;
    #1;
    for (int g = 0; g < NG; g++)
      chk(rdy[g] === 1'b0, "R6", "ready during clear", rdy[g], 0);
    @(posedge clk); @(negedge clk);
    clear = 1'b0; req_valid = 1'b0;
    model_clear();
    for (int g = 0; g < NG; g++)
      chk(rv[g] === 1'b0, "R6", "res_valid after clear", rv[g], 0);
    check_counters("R6");
    go_idle("R6");
    do_access(1'b0, 32'h1000_1000, "R5");
    do_access(1'b0, 32'h3000_0400, "R5");
    go_idle("R5");
  endtask

  // R9: 3-bit instance pinned at 7
  task automatic t_saturate();
    for (int i = 0; i < 12; i++) do_access(i[0], 32'h4000_0000 + 32'(i*64), "R9");
    chk(c1n[0] == 3'd7, "R9", "inst1 access count held", c1n[0], 7);
    chk(c0[0] == 32'd14, "R9", "inst0 access count", c0[0], 14);
    go_idle("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_conflict();
    t_write();
    t_clear();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule